// File: doc/BRIEF.md
# Lamp ballast phase sequencer

This block is the top-level state controller of a half-bridge lamp ballast. It reads digital flags from the supply comparators: supply above the start threshold, below the stop threshold, and below the reset level. It also reads a preheat-lock input and a flag that reports that the frequency controller has reached its bottom frequency. From these it steps through four phases: reset, preheat, ignition and burn. The analog parts (oscillator, sense comparators, power switches) are outside the block and appear only as flags.

Every output is registered. The outputs are an oscillator run enable, a request that forces the low-side switch on and the high-side switch off so the bootstrap capacitor can charge, a selector for the current-sense role (load-current regulation or capacitive-mode protection), a supply-path select flag, and a slow-sweep select for the frequency controller. A one-hot phase output lets the surrounding logic and benches follow every transition. The preheat length is the parameter `PH_TICKS`, counted in clock cycles. The ignition length is derived from it as `PH_TICKS - (PH_TICKS >> 4)`, which is 150 cycles for the default of 160.

Top module: `ballast_phase_seq`

## Requirements
- R1: When `rst` is high, and in the reset phase generally, `phase_onehot` = 4'b0001, `osc_run` = 0 and `boot_charge` = 1. `boot_charge` means low-side on, high-side off. `sense_capmode`, `supply_alt` and `sweep_slow` are all 0.
- R2: The block leaves reset only at a clock edge where `sup_start_ok` = 1 and both brown-out flags are 0. The next phase is always preheat (`phase_onehot` = 4'b0010).
- R3: With `preheat_lock` low, preheat lasts exactly `PH_TICKS` cycles. Its outputs are `osc_run` = 1 with `boot_charge`, `sense_capmode`, `supply_alt` and `sweep_slow` all 0.
- R4: While `preheat_lock` is high, the block stays in preheat and its timer is cleared. Ignition begins at the `PH_TICKS`-th consecutive preheat edge that samples the lock low.
- R5: From the first ignition cycle on, and in burn, `sense_capmode` = 1 (capacitive-mode protection) and `supply_alt` = 1.
- R6: Ignition (`phase_onehot` = 4'b0100) drives `osc_run` = 1 and `sweep_slow` = 1. With `fbtm_reached` low it lasts exactly `PH_TICKS - (PH_TICKS >> 4)` cycles.
- R7: In ignition, `fbtm_reached` = 1 at a clock edge moves the block to burn in the next cycle. In every other phase `fbtm_reached` has no effect.
- R8: Burn (`phase_onehot` = 4'b1000) drives `osc_run`, `sense_capmode` and `supply_alt` high and `sweep_slow` low. Burn persists until a brown-out flag is raised.
- R9: In any phase, `sup_below_stop` = 1 or `sup_below_rst` = 1 at a clock edge returns the block to reset in the next cycle and clears the timer. This takes priority over `sup_start_ok`, and the next preheat again lasts the full `PH_TICKS` cycles.
- R10: `phase_onehot` always has exactly one bit set. Bit 0 is reset, bit 1 preheat, bit 2 ignition and bit 3 burn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sup_start_ok | input | 1 | Supply has reached the start threshold |
| sup_below_stop | input | 1 | Supply is below the stop threshold |
| sup_below_rst | input | 1 | Supply is below the reset level |
| preheat_lock | input | 1 | Holds the block in preheat while high |
| fbtm_reached | input | 1 | Frequency controller is at bottom frequency |
| osc_run | output | 1 | Oscillator / half-bridge run enable |
| boot_charge | output | 1 | Force low-side on, high-side off |
| sense_capmode | output | 1 | 0: load-current regulation, 1: capacitive-mode protection |
| supply_alt | output | 1 | Supply-path select, set after preheat |
| sweep_slow | output | 1 | Slow downward sweep-rate select |
| phase_onehot | output | 4 | One-hot phase indicator |

## Verification
The corner that is hardest to reach from the ports is a preheat that actually completes. Ignition needs `PH_TICKS` consecutive edges with the lock low and no brown-out, so uniformly random lock and supply flags almost never get there. The random stimulus is therefore split into segments. Each segment draws its own lock and brown-out rates, and some segments hold the lock off entirely so the full preheat and ignition windows are crossed. Directed sequences add the remaining corners: a bottom-frequency pulse during preheat, an exact 20-cycle ignition cut short by that flag, and a brown-out in mid-preheat followed by a full-length restart.

// File: rtl/ballast_seq_pkg.sv
package ballast_seq_pkg;

  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned PHASE_W    = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_RST  = 2'd0,
    PH_HEAT = 2'd1,
    PH_IGN  = 2'd2,
    PH_BURN = 2'd3
  } bal_phase_t;

  typedef struct packed {
    logic osc_run;
    logic boot_chg;
    logic sense_cap;
    logic supply_alt;
    logic sweep_slow;
  } bal_ctl_t;

  // Control word each phase presents to the analog side.
  function automatic bal_ctl_t ctl_for(bal_phase_t p);
    bal_ctl_t c;
    c = '0;
    case (p)
      PH_RST:  c.boot_chg = 1'b1;
      PH_HEAT: c.osc_run  = 1'b1;
      PH_IGN: begin
        c.osc_run    = 1'b1;
        c.sense_cap  = 1'b1;
        c.supply_alt = 1'b1;
        c.sweep_slow = 1'b1;
      end
      PH_BURN: begin
        c.osc_run    = 1'b1;
        c.sense_cap  = 1'b1;
        c.supply_alt = 1'b1;
      end
      default: c.boot_chg = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ballast_phase_timer.sv
module ballast_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] count
);

  // Phase timer: cleared on every phase change and by the lock,
  // so it never runs past the terminal value the FSM compares to.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (en) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/ballast_phase_fsm.sv
module ballast_phase_fsm
  import ballast_seq_pkg::*;
#(
  parameter int unsigned PH_TICKS  = 160,
  parameter int unsigned IGN_TICKS = 150,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ok,
  input  logic             below_stop,
  input  logic             below_rst,
  input  logic             lock,
  input  logic             fbtm,
  input  logic [CNT_W-1:0] count,
  output bal_phase_t       phase,
  output bal_phase_t       nxt,
  output logic             tmr_clr,
  output logic             tmr_en
);

  localparam logic [CNT_W-1:0] HEAT_LAST = CNT_W'(PH_TICKS - 1);
  localparam logic [CNT_W-1:0] IGN_LAST  = CNT_W'(IGN_TICKS - 1);

  logic brown;
  logic heat_done;
  logic ign_done;

  assign brown     = below_stop | below_rst;
  assign heat_done = (count == HEAT_LAST) && !lock;
  assign ign_done  = (count == IGN_LAST) || fbtm;

  always_comb begin
    nxt = phase;
    if (brown) begin
      nxt = PH_RST;
    end else begin
      case (phase)
        PH_RST:  if (start_ok)  nxt = PH_HEAT;
        PH_HEAT: if (heat_done) nxt = PH_IGN;
        PH_IGN:  if (ign_done)  nxt = PH_BURN;
        PH_BURN: nxt = PH_BURN;
        default: nxt = PH_RST;
      endcase
    end
  end

  assign tmr_en  = (phase == PH_HEAT) || (phase == PH_IGN);
  assign tmr_clr = (nxt != phase) || (phase == PH_RST) ||
                   ((phase == PH_HEAT) && lock);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_RST;
    end else begin
      phase <= nxt;
    end
  end

endmodule

// File: rtl/ballast_out_reg.sv
module ballast_out_reg
  import ballast_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  bal_phase_t            nxt,
  output bal_ctl_t              ctl,
  output logic [NUM_PHASES-1:0] onehot
);

  logic [NUM_PHASES-1:0] oh_d;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_oh
    assign oh_d[g] = (PHASE_W'(nxt) == PHASE_W'(g));
  end

  // Outputs are decoded from the next phase so that they change on
  // the same edge as the phase register.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= ctl_for(PH_RST);
      onehot <= NUM_PHASES'(1);
    end else begin
      ctl    <= ctl_for(nxt);
      onehot <= oh_d;
    end
  end

endmodule

// File: rtl/ballast_phase_seq.sv
module ballast_phase_seq
  import ballast_seq_pkg::*;
#(
  parameter int unsigned PH_TICKS = 160
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sup_start_ok,
  input  logic       sup_below_stop,
  input  logic       sup_below_rst,
  input  logic       preheat_lock,
  input  logic       fbtm_reached,
  output logic       osc_run,
  output logic       boot_charge,
  output logic       sense_capmode,
  output logic       supply_alt,
  output logic       sweep_slow,
  output logic [3:0] phase_onehot
);

  localparam int unsigned IGN_TICKS = PH_TICKS - (PH_TICKS >> 4);
  localparam int unsigned CNT_W     = $clog2(PH_TICKS + 1);

  logic [CNT_W-1:0] count;
  bal_phase_t       phase;
  bal_phase_t       nxt;
  logic             tmr_clr;
  logic             tmr_en;
  bal_ctl_t         ctl;
  logic [NUM_PHASES-1:0] oh;

  ballast_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .count (count)
  );

  ballast_phase_fsm #(
    .PH_TICKS  (PH_TICKS),
    .IGN_TICKS (IGN_TICKS),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_ok   (sup_start_ok),
    .below_stop (sup_below_stop),
    .below_rst  (sup_below_rst),
    .lock       (preheat_lock),
    .fbtm       (fbtm_reached),
    .count      (count),
    .phase      (phase),
    .nxt        (nxt),
    .tmr_clr    (tmr_clr),
    .tmr_en     (tmr_en)
  );

  ballast_out_reg u_out (
    .clk    (clk),
    .rst    (rst),
    .nxt    (nxt),
    .ctl    (ctl),
    .onehot (oh)
  );

  assign osc_run       = ctl.osc_run;
  assign boot_charge   = ctl.boot_chg;
  assign sense_capmode = ctl.sense_cap;
  assign supply_alt    = ctl.supply_alt;
  assign sweep_slow    = ctl.sweep_slow;
  assign phase_onehot  = oh;

endmodule

// File: rtl/ballast_phase_seq_chk.sv
module ballast_phase_seq_chk #(
  parameter int unsigned PH_TICKS = 160
) (
  input logic       clk,
  input logic       rst,
  input logic       sup_start_ok,
  input logic       sup_below_stop,
  input logic       sup_below_rst,
  input logic       preheat_lock,
  input logic       fbtm_reached,
  input logic       osc_run,
  input logic       boot_charge,
  input logic       sense_capmode,
  input logic       supply_alt,
  input logic       sweep_slow,
  input logic [3:0] phase_onehot
);

  localparam int unsigned IGN_TICKS = PH_TICKS - (PH_TICKS >> 4);

  logic brown;
  int unsigned heat_run;
  int unsigned ign_run;

  assign brown = sup_below_stop | sup_below_rst;

  // Window counters built from the ports only.
  always_ff @(posedge clk) begin
    if (rst) begin
      heat_run <= 0;
      ign_run  <= 0;
    end else begin
      heat_run <= (phase_onehot[1] && !preheat_lock && !brown) ? heat_run + 1 : 0;
      ign_run  <= (phase_onehot[2] && !fbtm_reached && !brown) ? ign_run + 1 : 0;
    end
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_onehot) == 1);

  p_reset_out_r1: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[0] |-> (boot_charge && !osc_run && !sense_capmode && !supply_alt));

  p_hold_reset_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[0] && !sup_start_ok) |=> phase_onehot[0]);

  p_exit_reset_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[0] && sup_start_ok && !brown) |=> phase_onehot[1]);

  p_heat_max_r3: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[1] |-> (heat_run < PH_TICKS));

  p_heat_len_r3: assert property (@(posedge clk) disable iff (rst)
    (heat_run == PH_TICKS) |-> phase_onehot[2]);

  p_lock_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[1] && preheat_lock && !brown) |=> phase_onehot[1]);

  p_sense_role_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[2] || phase_onehot[3]) |-> (sense_capmode && supply_alt));

  p_ign_out_r6: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[2] |-> (sweep_slow && osc_run));

  p_ign_max_r6: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[2] |-> (ign_run < IGN_TICKS));

  p_ign_len_r6: assert property (@(posedge clk) disable iff (rst)
    (ign_run == IGN_TICKS) |-> phase_onehot[3]);

  p_fbtm_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[2] && fbtm_reached && !brown) |=> phase_onehot[3]);

  p_burn_out_r8: assert property (@(posedge clk) disable iff (rst)
    phase_onehot[3] |-> (osc_run && !sweep_slow && !boot_charge));

  p_burn_stay_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_onehot[3] && !brown) |=> phase_onehot[3]);

  p_brownout_r9: assert property (@(posedge clk) disable iff (rst)
    brown |=> (phase_onehot[0] && !osc_run));

endmodule

bind ballast_phase_seq ballast_phase_seq_chk #(.PH_TICKS(PH_TICKS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .sup_start_ok   (sup_start_ok),
  .sup_below_stop (sup_below_stop),
  .sup_below_rst  (sup_below_rst),
  .preheat_lock   (preheat_lock),
  .fbtm_reached   (fbtm_reached),
  .osc_run        (osc_run),
  .boot_charge    (boot_charge),
  .sense_capmode  (sense_capmode),
  .supply_alt     (supply_alt),
  .sweep_slow     (sweep_slow),
  .phase_onehot   (phase_onehot)
);

// File: tb/tb_ballast_phase_seq.sv
module tb_ballast_phase_seq;

  localparam int PH  = 160;
  localparam int IGN = PH - (PH >> 4);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_ok = 1'b0, below_stop = 1'b0, below_rst = 1'b0;
  logic lock = 1'b0, fbtm = 1'b0;
  logic osc_run, boot_charge, sense_capmode, supply_alt, sweep_slow;
  logic [3:0] phase_onehot;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  always #4 clk = ~clk;

  ballast_phase_seq #(.PH_TICKS(PH)) dut (
    .clk(clk), .rst(rst), .sup_start_ok(start_ok), .sup_below_stop(below_stop),
    .sup_below_rst(below_rst), .preheat_lock(lock), .fbtm_reached(fbtm),
    .osc_run(osc_run), .boot_charge(boot_charge), .sense_capmode(sense_capmode),
    .supply_alt(supply_alt), .sweep_slow(sweep_slow), .phase_onehot(phase_onehot)
  );

  // Expected control word {osc, boot, cap, supply, slow} per phase (R1, R3, R5, R6, R8).
  function automatic logic [4:0] exp_ctl(int st);
    case (st)
      0: return 5'b01000;
      1: return 5'b10000;
      2: return 5'b10111;
      default: return 5'b10110;
    endcase
  endfunction

  function automatic string tag_of(int st);
    case (st)
      0: return "R1";
      1: return "R3";
      2: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Reference model built from the requirements.
  int m_st = 0;
  int m_run = 0;
  always @(posedge clk) begin
    if (rst || below_stop || below_rst) begin
      m_st  <= 0;
      m_run <= 0;
    end else begin
      case (m_st)
        0: if (start_ok) begin m_st <= 1; m_run <= 0; end
        1: if (lock) m_run <= 0;
           else if (m_run + 1 == PH) begin m_st <= 2; m_run <= 0; end
           else m_run <= m_run + 1;
        2: if (fbtm || (m_run + 1 == IGN)) begin m_st <= 3; m_run <= 0; end
           else m_run <= m_run + 1;
        default: ;
      endcase
    end
  end

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (live) begin
      chk(phase_onehot == 4'(1 << m_st), "R10", phase_onehot, 1 << m_st);
      chk({osc_run, boot_charge, sense_capmode, supply_alt, sweep_slow} == exp_ctl(m_st),
          tag_of(m_st), {osc_run, boot_charge, sense_capmode, supply_alt, sweep_slow},
          exp_ctl(m_st));
    end
  end

  task automatic measure(logic [3:0] code, output int n);
    n = 0;
    while (phase_onehot == code && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int n;
    int lrate, brate, frate;
    void'($urandom(32'd2718));
    @(posedge clk);
    live = 1'b1;
    repeat (3) @(negedge clk);
    chk(phase_onehot == 4'b0001 && boot_charge && !osc_run, "R1", phase_onehot, 1);
    rst = 1'b0;

    repeat (20) @(negedge clk);
    chk(phase_onehot == 4'b0001, "R2 hold without start", phase_onehot, 1);

    start_ok = 1'b1; below_stop = 1'b1;
    @(negedge clk);
    chk(phase_onehot == 4'b0001, "R9 priority over start", phase_onehot, 1);
    below_stop = 1'b0;
    @(negedge clk);
    chk(phase_onehot == 4'b0010, "R2 enter preheat", phase_onehot, 2);

    fbtm = 1'b1;
    repeat (50) @(negedge clk);
    chk(phase_onehot == 4'b0010, "R7 fbtm ignored in preheat", phase_onehot, 2);
    fbtm = 1'b0;
    measure(4'b0010, n);
    chk(n + 50 == PH, "R3 preheat length", n + 50, PH);
    chk(sense_capmode && supply_alt, "R5 role switch", {sense_capmode, supply_alt}, 3);
    chk(sweep_slow, "R6 slow sweep", sweep_slow, 1);
    measure(4'b0100, n);
    chk(n == IGN, "R6 ignition length", n, IGN);
    chk(phase_onehot == 4'b1000 && !sweep_slow, "R8 burn entry", phase_onehot, 8);
    repeat (40) @(negedge clk);
    chk(phase_onehot == 4'b1000, "R8 burn holds", phase_onehot, 8);

    below_rst = 1'b1;
    @(negedge clk);
    chk(phase_onehot == 4'b0001 && !osc_run, "R9 brownout from burn", phase_onehot, 1);
    below_rst = 1'b0;
    @(negedge clk);
    lock = 1'b1;
    repeat (300) @(negedge clk);
    chk(phase_onehot == 4'b0010, "R4 lock holds preheat", phase_onehot, 2);
    lock = 1'b0;
    measure(4'b0010, n);
    chk(n == PH, "R4 full preheat after lock", n, PH);

    repeat (19) @(negedge clk);
    fbtm = 1'b1;
    @(negedge clk);
    chk(phase_onehot == 4'b1000, "R7 fbtm ends ignition", phase_onehot, 8);
    fbtm = 1'b0;

    below_stop = 1'b1;
    @(negedge clk);
    below_stop = 1'b0;
    @(negedge clk);
    repeat (100) @(negedge clk);
    below_stop = 1'b1;
    @(negedge clk);
    chk(phase_onehot == 4'b0001, "R9 brownout in preheat", phase_onehot, 1);
    below_stop = 1'b0;
    @(negedge clk);
    measure(4'b0010, n);
    chk(n == PH, "R9 timer cleared", n, PH);

    // Random segments with their own lock / brown-out / fbtm rates.
    for (int s = 0; s < 20; s++) begin
      lrate = (($urandom % 3) == 0) ? 4 : 0;
      brate = 300 + ($urandom % 1500);
      frate = 20 + ($urandom % 200);
      for (int c = 0; c < 400; c++) begin
        start_ok   = ($urandom % 8) != 0;
        below_stop = ($urandom % brate) == 0;
        below_rst  = ($urandom % (brate * 3)) == 0;
        lock       = (lrate != 0) && (($urandom % lrate) != 0);
        fbtm       = ($urandom % frate) == 0;
        rst        = ($urandom % 4000) == 0;
        @(negedge clk);
      end
    end
    rst = 1'b0;
    @(negedge clk);
    finish_up();
  end

endmodule